// File: doc/BRIEF.md
# Receive Interrupt Blanking Timer

This block decides when a receive-done event may be reported to the interrupt status logic. Each raw receive-done event is held as pending. It is released only when one of two conditions is met. The first is that more completion writebacks have occurred since software last read the status than a configured packet limit allows. The second is that more time units have elapsed since that read than a configured time limit allows, where one time unit is 512 core clocks. Setting a limit to zero turns off that condition. When both limits are zero the event goes straight through.

Software reading the status restarts both counts and the 512-clock prescaler, and it consumes the pending event. The block is built as a set of independent paths, with the number of paths set by a parameter. Path 0 serves the normal status read. Path 1 serves the alias status read and has its own restart pulse and its own limit word. All paths share the writeback pulse and the raw event.

Top module: `rx_blank_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every qualified output is low.
- R2: The packet limit is the 9-bit field at bits [8:0] of a path's limit word. With a non-zero packet limit L, the output rises one cycle after the edge that counts writeback number L+1 since the last read, provided an event is pending.
- R3: The time limit is the 18-bit field at bits [29:12]. A time unit is 512 clocks, counted from the read edge. With a non-zero time limit T, the output rises on the edge one cycle after the (T+1)*512th clock edge following the read, provided an event is pending.
- R4: A limit of zero disables its own condition. Writebacks never release an event when the packet limit is zero and the time limit is non-zero.
- R5: With both limits zero, a raw event sampled on an edge drives the output high on that same edge, so the output is high in the following cycle.
- R6: A read on a path clears that path's output on the read edge. It restarts the writeback count and the time count from zero. A writeback in the read cycle itself is not counted.
- R7: With no pending event the output stays low, however far the counts have run. A later event is released on the next edge if a condition is already met.
- R8: The counters saturate instead of wrapping. With limit 511, 520 writebacks still release the event.
- R9: A read on path 1 (the alias read) affects only path 1, and a read on path 0 affects only path 0. Each path uses its own limit word.
- R10: Either condition alone releases the event. The packet condition fires even when a non-zero time limit has not yet expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | core clock |
| rst_i | input | 1 | synchronous active-high reset |
| wb_pulse_i | input | 1 | one completion writeback per high cycle |
| raw_done_i | input | 1 | raw receive-done event, one per high cycle |
| stat_rd_i | input | NUM_PATHS | per-path status-read pulse (bit 0 normal, bit 1 alias) |
| blank_cfg_i | input | NUM_PATHS*32 | per-path limit words, packet [8:0], time [29:12] |
| done_qual_o | output | NUM_PATHS | qualified receive-done per path |

## Verification
The bench targets the exact release edge for both conditions. A design that compared with greater-or-equal, or that added or dropped a register stage, would release one writeback or one cycle early or late. A prescaler that is not restarted by the read would shift the time release by up to 511 clocks. A 9-bit wrapping counter would go quiet after 520 writebacks with limit 511. Counting the writeback in the read cycle, or letting one path's read clear the other, would release the event early or drop it.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int CFG_W    = 32;
  localparam int PKT_LSB  = 0;
  localparam int PKT_W    = 9;
  localparam int TIME_LSB = 12;
  localparam int TIME_W   = 18;
  localparam int PKT_CNT_W  = PKT_W + 1;
  localparam int TIME_CNT_W = TIME_W + 1;

  typedef struct packed {
    logic [PKT_W-1:0]  pkt_lim;
    logic [TIME_W-1:0] time_lim;
  } blank_lim_t;
endpackage

// File: rtl/rxb_sat_counter.sv
module rxb_sat_counter #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && cnt_q != MAXV) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R8: a full counter holds its value until cleared
  a_r8_saturate: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q == MAXV && !clr_i) |=> cnt_q == MAXV);

  // R6: a clear restarts the count
  a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/rxb_prescaler.sv
module rxb_prescaler #(
  parameter int DIV = 512
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick_o = (div_q == LAST) && !clr_i;

  // R3: two ticks are never adjacent
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rxb_path.sv
module rxb_path
  import rxb_pkg::*;
#(
  parameter int PRESCALE = 512
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       wb_i,
  input  logic       raw_i,
  input  logic       rd_i,
  input  blank_lim_t lim_i,
  output logic       qual_o
);
  logic [PKT_CNT_W-1:0]  pkt_cnt;
  logic [TIME_CNT_W-1:0] time_cnt;
  logic                  unit_tick;
  logic                  pend_q;
  logic                  qual_q;
  logic                  pkt_hit;
  logic                  time_hit;
  logic                  bypass;
  logic                  release_ok;

  rxb_sat_counter #(.W(PKT_CNT_W)) u_pkt_cnt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .clr_i (rd_i),
    .inc_i (wb_i),
    .cnt_o (pkt_cnt)
  );

  rxb_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (rd_i),
    .tick_o (unit_tick)
  );

  rxb_sat_counter #(.W(TIME_CNT_W)) u_time_cnt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .clr_i (rd_i),
    .inc_i (unit_tick),
    .cnt_o (time_cnt)
  );

  always_comb begin
    bypass     = (lim_i.pkt_lim == '0) && (lim_i.time_lim == '0);
    pkt_hit    = (lim_i.pkt_lim != '0) && (pkt_cnt > {1'b0, lim_i.pkt_lim});
    time_hit   = (lim_i.time_lim != '0) && (time_cnt > {1'b0, lim_i.time_lim});
    release_ok = bypass || pkt_hit || time_hit;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q <= 1'b0;
      qual_q <= 1'b0;
    end else begin
      pend_q <= raw_i || (pend_q && !rd_i);
      qual_q <= (pend_q || raw_i) && !rd_i && release_ok;
    end
  end

  assign qual_o = qual_q;

  // R7: the output needs a pending or fresh event
  a_r7_needs_event: assert property (@(posedge clk_i) disable iff (rst_i)
    qual_q |-> $past(pend_q || raw_i));

  // R6: a read drops the output on the read edge
  a_r6_read_drops: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_i |=> !qual_q);

  // R5: both limits zero pass an event on the next edge
  a_r5_bypass: assert property (@(posedge clk_i) disable iff (rst_i)
    (raw_i && !rd_i && lim_i.pkt_lim == '0 && lim_i.time_lim == '0) |=> qual_q);

  // R3: the time count moves only on a prescaler tick or a read
  a_r3_time_on_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(time_cnt) && !$past(rd_i)) |-> $past(unit_tick));
endmodule

// File: rtl/rx_blank_timer.sv
module rx_blank_timer
  import rxb_pkg::*;
#(
  parameter int NUM_PATHS = 2,
  parameter int PRESCALE  = 512
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       wb_pulse_i,
  input  logic                       raw_done_i,
  input  logic [NUM_PATHS-1:0]       stat_rd_i,
  input  logic [NUM_PATHS*CFG_W-1:0] blank_cfg_i,
  output logic [NUM_PATHS-1:0]       done_qual_o
);
  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic [CFG_W-1:0] cfg_word;
    blank_lim_t       lim;
    logic [CFG_W-1:0] cfg_unused;

    assign cfg_word     = blank_cfg_i[p*CFG_W +: CFG_W];
    assign lim.pkt_lim  = cfg_word[PKT_LSB +: PKT_W];
    assign lim.time_lim = cfg_word[TIME_LSB +: TIME_W];
    assign cfg_unused   = cfg_word;

    rxb_path #(.PRESCALE(PRESCALE)) u_path (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .wb_i   (wb_pulse_i),
      .raw_i  (raw_done_i),
      .rd_i   (stat_rd_i[p]),
      .lim_i  (lim),
      .qual_o (done_qual_o[p])
    );
  end

  // R1: outputs are low in the cycle after reset
  a_r1_reset_low: assert property (@(posedge clk_i)
    $past(rst_i) |-> done_qual_o == '0);
endmodule

// File: tb/rx_blank_timer_test.sv
module rx_blank_timer_test;
  localparam int NP = 2;

  logic            clk = 0;
  logic            rst = 1;
  logic            wb = 0;
  logic            raw = 0;
  logic [NP-1:0]   rd = '0;
  logic [NP*32-1:0] cfg = '0;
  logic [NP-1:0]   qual;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rx_blank_timer #(.NUM_PATHS(NP), .PRESCALE(512)) uut (
    .clk_i       (clk),
    .rst_i       (rst),
    .wb_pulse_i  (wb),
    .raw_done_i  (raw),
    .stat_rd_i   (rd),
    .blank_cfg_i (cfg),
    .done_qual_o (qual)
  );

  function automatic logic [31:0] mk_cfg(int pkt, int tm);
    logic [31:0] w;
    w = '0;
    w[8:0]   = pkt[8:0];
    w[29:12] = tm[17:0];
    return w;
  endfunction

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(logic act, logic exp, string req, string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(int p, int pkt, int tm);
    cfg[p*32 +: 32] = mk_cfg(pkt, tm);
  endtask

  task automatic do_read(logic [NP-1:0] which);
    rd = which; tick(1); rd = '0;
  endtask

  task automatic pulse_raw();
    raw = 1; tick(1); raw = 0;
  endtask

  task automatic send_wb(int n);
    wb = 1; tick(n); wb = 0;
  endtask

  task automatic t_reset();
    tick(1);
    check(qual[0], 1'b0, "R1", "path0 in reset");
    check(qual[1], 1'b0, "R1", "path1 in reset");
    rst = 0; tick(1);
    check(qual[0], 1'b0, "R1", "path0 after reset");
  endtask

  task automatic t_bypass();
    set_cfg(0, 0, 0); set_cfg(1, 0, 0);
    do_read(2'b11);
    raw = 1; tick(1); raw = 0;
    check(qual[0], 1'b1, "R5", "bypass next edge");
    tick(1);
    check(qual[0], 1'b1, "R5", "stays pending");
    do_read(2'b11);
    check(qual[0], 1'b0, "R6", "read drops output");
  endtask

  task automatic t_packet();
    set_cfg(0, 3, 0);
    do_read(2'b01);
    pulse_raw();
    check(qual[0], 1'b0, "R2", "no writebacks yet");
    send_wb(3); tick(1);
    check(qual[0], 1'b0, "R2", "count equal to limit");
    send_wb(1);
    check(qual[0], 1'b0, "R2", "edge of 4th writeback");
    tick(1);
    check(qual[0], 1'b1, "R2", "one cycle after 4th writeback");
    do_read(2'b01);
  endtask

  task automatic t_no_pending();
    set_cfg(0, 1, 0);
    do_read(2'b01);
    send_wb(5); tick(2);
    check(qual[0], 1'b0, "R7", "counts met, nothing pending");
    pulse_raw();
    check(qual[0], 1'b1, "R7", "late event released next edge");
    do_read(2'b01);
  endtask

  task automatic t_restart();
    set_cfg(0, 2, 0);
    do_read(2'b01);
    pulse_raw();
    send_wb(2);
    rd = 2'b01; wb = 1; tick(1); rd = '0; wb = 0;
    pulse_raw();
    send_wb(2); tick(2);
    check(qual[0], 1'b0, "R6", "count restarted, read-cycle writeback ignored");
    send_wb(1); tick(1);
    check(qual[0], 1'b1, "R6", "third writeback after read releases");
    do_read(2'b01);
  endtask

  task automatic t_time();
    set_cfg(0, 0, 2);
    do_read(2'b01);
    pulse_raw();
    send_wb(10);
    check(qual[0], 1'b0, "R4", "writebacks ignored with packet limit zero");
    tick(1536 - 11);
    check(qual[0], 1'b0, "R3", "edge where count reaches 3");
    tick(1);
    check(qual[0], 1'b1, "R3", "one cycle after 3 time units");
    do_read(2'b01);
  endtask

  task automatic t_either();
    set_cfg(0, 4, 100);
    do_read(2'b01);
    pulse_raw();
    send_wb(5); tick(1);
    check(qual[0], 1'b1, "R10", "packet condition alone releases");
    do_read(2'b01);
  endtask

  task automatic t_saturate();
    set_cfg(0, 511, 0);
    do_read(2'b01);
    pulse_raw();
    send_wb(511); tick(1);
    check(qual[0], 1'b0, "R8", "511 writebacks equal limit");
    send_wb(9); tick(1);
    check(qual[0], 1'b1, "R8", "520 writebacks exceed limit");
    do_read(2'b01);
  endtask

  task automatic t_alias();
    set_cfg(0, 2, 0); set_cfg(1, 2, 0);
    do_read(2'b11);
    pulse_raw();
    send_wb(3); tick(1);
    check(qual[0], 1'b1, "R9", "path0 released");
    check(qual[1], 1'b1, "R9", "path1 released");
    do_read(2'b01);
    check(qual[0], 1'b0, "R9", "path0 cleared by its read");
    check(qual[1], 1'b1, "R9", "path1 untouched by path0 read");
    pulse_raw(); tick(1);
    check(qual[0], 1'b0, "R9", "path0 count restarted");
    check(qual[1], 1'b1, "R9", "path1 count kept");
    send_wb(3); tick(1);
    check(qual[0], 1'b1, "R9", "path0 releases after own count");
    do_read(2'b10);
    check(qual[1], 1'b0, "R9", "path1 cleared by alias read");
    check(qual[0], 1'b1, "R9", "path0 untouched by alias read");
    do_read(2'b11);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_packet();
    t_no_pending();
    t_restart();
    t_time();
    t_either();
    t_saturate();
    t_alias();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule